// File: doc/BRIEF.md
# Paged Address Translation Buffer

This block is a fully associative translation buffer for a 32-bit processor. It holds recently used mappings from logical page numbers to physical frames. Each request carries a logical address whose top bit selects one of two address regions. Each region has its own page-table root, and the region bit is stored in every entry, so a mapping learned in one region never matches a request in the other. A request that matches a valid entry returns its physical address on the next clock edge. The buffer accepts a new request every cycle while it keeps hitting, so translation overlaps the memory access of the previous request.

A request that matches no entry starts a hardware walk of a two-level page table through a simple memory read port. The first-level entry is found from the region root and the upper page-number bits. The second-level entry is found from the first-level pointer and the lower page-number bits. A valid leaf is installed in the slot chosen by a round-robin pointer and returned as the response. An invalid entry at either level ends the walk with a fault flag and installs nothing. A flush input clears the whole buffer in one cycle.

Top module: `page_xlate_tlb`

## Requirements
- R1: A request accepted (`req_valid` and `req_ready` high at a rising edge) that matches a valid entry gives `resp_valid`=1, `resp_fault`=0 and `resp_paddr` = {entry frame, `req_addr[11:0]`} after that same edge, and issues no memory read.
- R2: The region is `req_addr[31]`. Region 0 walks start from `root0` and region 1 walks start from `root1`. An entry matches only requests of the region it was installed from.
- R3: On a miss the walker first reads `root + 4*req_addr[30:22]`. It then reads `{pte1[31:12], 12'h0} + 4*req_addr[21:12]`. Each read is a one-cycle `mem_rd_en` strobe, and the data is taken when `mem_rd_valid` is high. Bit 0 of a table word is its valid bit and bits 31:12 hold the frame. The result is `{pte2[31:12], req_addr[11:0]}`.
- R4: `req_ready` is low from the edge that accepts a miss until its response. That response appears after the edge at which the second read data is returned, and the new entry can hit on the next request.
- R5: If either table word has bit 0 clear, the walk ends with `resp_valid`=1, `resp_fault`=1 and `resp_paddr`=0. No further read is made and nothing is installed, so a repeated request walks again.
- R6: The buffer holds 32 entries. Installs fill slots in round-robin order starting at slot 0 after reset or flush. The 33rd install replaces the oldest entry, and at most one entry matches any request.
- R7: `inval_all` clears every entry in one cycle and resets the round-robin pointer. Requests in later cycles miss, and an install landing in the flush cycle is dropped.
- R8: Back-to-back hits are accepted on consecutive cycles, and each response follows its own request by one cycle.
- R9: After reset the buffer is empty, `req_ready`=1, `resp_valid`=0 and `mem_rd_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_addr | input | 32 | Logical address; bit 31 is the region |
| req_ready | output | 1 | Buffer can take a request (no walk running) |
| root0 | input | 32 | First-level table base for region 0 |
| root1 | input | 32 | First-level table base for region 1 |
| inval_all | input | 1 | Clear all entries |
| resp_valid | output | 1 | Response strobe |
| resp_paddr | output | 32 | Physical address (0 on fault) |
| resp_fault | output | 1 | Walk found an invalid table word |
| mem_rd_en | output | 1 | Table read strobe |
| mem_rd_addr | output | 32 | Table read byte address |
| mem_rd_valid | input | 1 | Table read data valid |
| mem_rd_data | input | 32 | Table read data |

## Verification
The bench uses the default parameters: 32 entries, 4 KiB pages and a 9/10-bit split of the page number. With 32 entries the round-robin wrap is reached after 33 installs. A page table produced by bench functions places first-level and second-level faults at chosen indices, and the same rules give the expected physical address. The memory model answers after a fixed latency. This exercises the wait states of the walk, the region roots and the single-cycle hit path, including back-to-back hits and hits on entries refilled after a flush.

// File: rtl/ptlb_pkg.sv
package ptlb_pkg;
  typedef enum logic [2:0] {
    WK_IDLE,
    WK_RD1,
    WK_WT1,
    WK_RD2,
    WK_WT2
  } walk_state_t;
endpackage

// File: rtl/ptlb_cam.sv
module ptlb_cam #(
  parameter int ENTRIES = 32,
  parameter int TAG_W   = 20,
  parameter int FRAME_W = 20
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic [TAG_W-1:0]   lk_tag,
  output logic               lk_hit,
  output logic [FRAME_W-1:0] lk_frame,
  output logic [ENTRIES-1:0] hit_vec,
  output logic [ENTRIES-1:0] valid_vec,
  input  logic               wr_en,
  input  logic [TAG_W-1:0]   wr_tag,
  input  logic [FRAME_W-1:0] wr_frame
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [TAG_W-1:0]   tag_q   [ENTRIES];
  logic [FRAME_W-1:0] frame_q [ENTRIES];
  logic [ENTRIES-1:0] valid_q;
  logic [IDX_W-1:0]   ptr_q;

  assign valid_vec = valid_q;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_match
    assign hit_vec[i] = valid_q[i] && (tag_q[i] == lk_tag);
  end

  always_comb begin
    lk_frame = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) lk_frame = lk_frame | frame_q[i];
    end
  end
  assign lk_hit = |hit_vec;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      valid_q <= '0;
      ptr_q   <= '0;
    end else if (wr_en) begin
      valid_q[ptr_q] <= 1'b1;
      ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !flush) begin
      tag_q[ptr_q]   <= wr_tag;
      frame_q[ptr_q] <= wr_frame;
    end
  end
endmodule

// File: rtl/ptlb_walker.sv
module ptlb_walker
  import ptlb_pkg::*;
#(
  parameter int PA_W   = 32,
  parameter int PAGE_W = 12,
  parameter int L1_W   = 9,
  parameter int L2_W   = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 st_region,
  input  logic [L1_W-1:0]      st_l1,
  input  logic [L2_W-1:0]      st_l2,
  input  logic [PA_W-1:0]      root0,
  input  logic [PA_W-1:0]      root1,
  output logic                 idle,
  output logic                 mem_rd_en,
  output logic [PA_W-1:0]      mem_rd_addr,
  input  logic                 mem_rd_valid,
  input  logic [PA_W-1:0]      mem_rd_data,
  output logic                 done,
  output logic                 done_fault,
  output logic [PA_W-PAGE_W-1:0] done_frame
);
  localparam int FRAME_W = PA_W - PAGE_W;

  walk_state_t       st_q;
  logic [PA_W-1:0]   addr_q;
  logic [L2_W-1:0]   l2_q;
  logic [PA_W-1:0]   root_sel;

  assign root_sel    = st_region ? root1 : root0;
  assign idle        = (st_q == WK_IDLE);
  assign mem_rd_en   = (st_q == WK_RD1) || (st_q == WK_RD2);
  assign mem_rd_addr = addr_q;

  assign done       = (st_q == WK_WT2 && mem_rd_valid) ||
                      (st_q == WK_WT1 && mem_rd_valid && !mem_rd_data[0]);
  assign done_fault = !mem_rd_data[0];
  assign done_frame = mem_rd_data[PA_W-1:PAGE_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= WK_IDLE;
      addr_q <= '0;
      l2_q   <= '0;
    end else begin
      unique case (st_q)
        WK_IDLE: if (start) begin
          addr_q <= root_sel + PA_W'({st_l1, 2'b00});
          l2_q   <= st_l2;
          st_q   <= WK_RD1;
        end
        WK_RD1: st_q <= WK_WT1;
        WK_WT1: if (mem_rd_valid) begin
          if (mem_rd_data[0]) begin
            addr_q <= {mem_rd_data[PA_W-1:PAGE_W], PAGE_W'(0)} + PA_W'({l2_q, 2'b00});
            st_q   <= WK_RD2;
          end else begin
            st_q <= WK_IDLE;
          end
        end
        WK_RD2: st_q <= WK_WT2;
        WK_WT2: if (mem_rd_valid) st_q <= WK_IDLE;
        default: st_q <= WK_IDLE;
      endcase
    end
  end

  logic unused_frame_w;
  assign unused_frame_w = (FRAME_W == 0);
endmodule

// File: rtl/page_xlate_tlb.sv
module page_xlate_tlb #(
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int PAGE_W  = 12,
  parameter int L2_W    = 10,
  parameter int ENTRIES = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [VA_W-1:0] req_addr,
  output logic            req_ready,
  input  logic [PA_W-1:0] root0,
  input  logic [PA_W-1:0] root1,
  input  logic            inval_all,
  output logic            resp_valid,
  output logic [PA_W-1:0] resp_paddr,
  output logic            resp_fault,
  output logic            mem_rd_en,
  output logic [PA_W-1:0] mem_rd_addr,
  input  logic            mem_rd_valid,
  input  logic [PA_W-1:0] mem_rd_data
);
  localparam int VPN_W   = VA_W - 1 - PAGE_W;
  localparam int L1_W    = VPN_W - L2_W;
  localparam int TAG_W   = VPN_W + 1;
  localparam int FRAME_W = PA_W - PAGE_W;

  logic [TAG_W-1:0]   lk_tag;
  logic               lk_hit;
  logic [FRAME_W-1:0] lk_frame;
  logic [ENTRIES-1:0] hit_vec;
  logic [ENTRIES-1:0] valid_vec;
  logic               accept;
  logic               wk_start, wk_idle, wk_done, wk_fault;
  logic [FRAME_W-1:0] wk_frame;
  logic [TAG_W-1:0]   miss_tag_q;
  logic [PAGE_W-1:0]  miss_off_q;

  assign lk_tag    = req_addr[VA_W-1:PAGE_W];
  assign req_ready = wk_idle;
  assign accept    = req_valid && req_ready;
  assign wk_start  = accept && !lk_hit;

  ptlb_cam #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .FRAME_W(FRAME_W)) u_cam (
    .clk(clk), .rst(rst), .flush(inval_all),
    .lk_tag(lk_tag), .lk_hit(lk_hit), .lk_frame(lk_frame),
    .hit_vec(hit_vec), .valid_vec(valid_vec),
    .wr_en(wk_done && !wk_fault), .wr_tag(miss_tag_q), .wr_frame(wk_frame)
  );

  ptlb_walker #(.PA_W(PA_W), .PAGE_W(PAGE_W), .L1_W(L1_W), .L2_W(L2_W)) u_walk (
    .clk(clk), .rst(rst), .start(wk_start),
    .st_region(req_addr[VA_W-1]),
    .st_l1(req_addr[VA_W-2 -: L1_W]),
    .st_l2(req_addr[PAGE_W +: L2_W]),
    .root0(root0), .root1(root1), .idle(wk_idle),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .done(wk_done), .done_fault(wk_fault), .done_frame(wk_frame)
  );

  always_ff @(posedge clk) begin
    if (wk_start) begin
      miss_tag_q <= lk_tag;
      miss_off_q <= req_addr[PAGE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_fault <= 1'b0;
      resp_paddr <= '0;
    end else begin
      resp_valid <= 1'b0;
      resp_fault <= 1'b0;
      if (accept && lk_hit) begin
        resp_valid <= 1'b1;
        resp_paddr <= {lk_frame, req_addr[PAGE_W-1:0]};
      end else if (wk_done) begin
        resp_valid <= 1'b1;
        resp_fault <= wk_fault;
        resp_paddr <= wk_fault ? '0 : {wk_frame, miss_off_q};
      end
    end
  end
endmodule

// File: rtl/page_xlate_tlb_chk.sv
module page_xlate_tlb_chk #(
  parameter int ENTRIES = 32,
  parameter int PA_W    = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic               req_ready,
  input logic               inval_all,
  input logic               resp_valid,
  input logic               resp_fault,
  input logic [PA_W-1:0]    resp_paddr,
  input logic               mem_rd_en,
  input logic [ENTRIES-1:0] hit_vec,
  input logic [ENTRIES-1:0] valid_vec
);
  p_accept_resp_r1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (resp_valid || !req_ready));

  p_rd_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> !mem_rd_en);

  p_busy_no_ready_r4: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> !req_ready);

  p_fault_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_fault) |-> (resp_paddr == '0));

  p_single_match_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));

  p_flush_clear_r7: assert property (@(posedge clk) disable iff (rst)
    inval_all |=> (valid_vec == '0));
endmodule

bind page_xlate_tlb page_xlate_tlb_chk #(.ENTRIES(ENTRIES), .PA_W(PA_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .inval_all(inval_all), .resp_valid(resp_valid), .resp_fault(resp_fault),
  .resp_paddr(resp_paddr), .mem_rd_en(mem_rd_en),
  .hit_vec(hit_vec), .valid_vec(valid_vec)
);

// File: tb/page_xlate_tlb_bench.sv
module page_xlate_tlb_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_LAT    = 2;
  localparam logic [31:0] ROOT0 = 32'h0010_0000;
  localparam logic [31:0] ROOT1 = 32'h0020_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_ready;
  logic        inval_all = 1'b0;
  logic        resp_valid, resp_fault;
  logic [31:0] resp_paddr;
  logic        mem_rd_en;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_valid = 1'b0;
  logic [31:0] mem_rd_data = '0;

  int checks = 0;
  int errors = 0;
  int rd_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  page_xlate_tlb u_page_xlate_tlb (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .root0(ROOT0), .root1(ROOT1), .inval_all(inval_all),
    .resp_valid(resp_valid), .resp_paddr(resp_paddr), .resp_fault(resp_fault),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data)
  );

  function automatic logic [31:0] mkva(input logic r, input int l1, input int l2, input int off);
    return {r, 9'(l1), 10'(l2), 12'(off)};
  endfunction

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    int idx;
    logic [31:0] base;
    if (a >= ROOT0 && a < ROOT0 + 32'd2048) begin
      idx = int'((a - ROOT0) >> 2);
      base = 32'h0100_0000 + (32'(idx) << 12);
      return {base[31:12], 11'd0, (idx % 5) != 3};
    end else if (a >= ROOT1 && a < ROOT1 + 32'd2048) begin
      idx = int'((a - ROOT1) >> 2);
      base = 32'h0180_0000 + (32'(idx) << 12);
      return {base[31:12], 11'd0, (idx % 5) != 3};
    end else if (a[31:24] == 8'h01) begin
      idx = int'(a[11:2]);
      return {({a[23], a[20:12], a[11:2]} ^ 20'hA5A5A), 11'd0, (idx % 7) != 6};
    end
    return 32'h0;
  endfunction

  function automatic logic exp_fault(input logic [31:0] va);
    return (int'(va[30:22]) % 5 == 3) || (int'(va[21:12]) % 7 == 6);
  endfunction

  function automatic logic [31:0] exp_pa(input logic [31:0] va);
    if (exp_fault(va)) return 32'h0;
    return {({va[31], va[30:22], va[21:12]} ^ 20'hA5A5A), va[11:0]};
  endfunction

  logic        pend = 1'b0;
  int          pcnt = 0;
  logic [31:0] paddr_q = '0;
  always @(posedge clk) begin
    mem_rd_valid <= 1'b0;
    if (mem_rd_en) begin
      rd_cnt <= rd_cnt + 1;
      pend <= 1'b1;
      pcnt <= MEM_LAT;
      paddr_q <= mem_rd_addr;
    end else if (pend) begin
      if (pcnt == 0) begin
        mem_rd_valid <= 1'b1;
        mem_rd_data <= mem_word(paddr_q);
        pend <= 1'b0;
      end else begin
        pcnt <= pcnt - 1;
      end
    end
  end

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic xlate(input logic [31:0] va, output int cyc, output logic flt,
                       output logic [31:0] pa, output int reads);
    int r0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    r0 = rd_cnt;
    req_valid = 1'b1;
    req_addr = va;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    while (!resp_valid && cyc < 1000) begin
      @(negedge clk);
      cyc++;
    end
    flt = resp_fault;
    pa = resp_paddr;
    reads = rd_cnt - r0;
  endtask

  task automatic expect_hit(input string req, input logic [31:0] va);
    int cyc, rd; logic f; logic [31:0] pa;
    xlate(va, cyc, f, pa, rd);
    check(req, "hit latency", 32'(cyc), 32'd1);
    check(req, "hit reads", 32'(rd), 32'd0);
    check(req, "hit paddr", pa, exp_pa(va));
  endtask

  task automatic expect_miss(input string req, input logic [31:0] va, input int exp_reads);
    int cyc, rd; logic f; logic [31:0] pa;
    xlate(va, cyc, f, pa, rd);
    checks++;
    if (cyc <= 1) begin
      errors++;
      $display("FAIL %s miss latency: actual %0d expected >1", req, cyc);
    end
    check(req, "walk reads", 32'(rd), 32'(exp_reads));
    check(req, "fault", 32'(f), 32'(exp_fault(va)));
    check(req, "paddr", pa, exp_pa(va));
  endtask

  task automatic flush();
    @(negedge clk);
    inval_all = 1'b1;
    @(negedge clk);
    inval_all = 1'b0;
  endtask

  logic finished = 1'b0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] pool [8];
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check("R9", "req_ready", 32'(req_ready), 32'd1);
    check("R9", "resp_valid", 32'(resp_valid), 32'd0);
    check("R9", "mem_rd_en", 32'(mem_rd_en), 32'd0);

    // R3 walk, then R1 hit on same page with another offset
    expect_miss("R3", mkva(0, 5, 17, 12'h123), 2);
    expect_hit("R1", mkva(0, 5, 17, 12'hABC));
    // R4 new entry usable right after walk; R2 other region is a separate mapping
    expect_miss("R2", mkva(1, 5, 17, 12'h040), 2);
    expect_hit("R2", mkva(1, 5, 17, 12'h044));
    expect_hit("R4", mkva(0, 5, 17, 12'h000));

    // R5 faults at level one and two, not installed
    expect_miss("R5", mkva(0, 3, 2, 0), 1);
    expect_miss("R5", mkva(0, 3, 2, 4), 1);
    expect_miss("R5", mkva(1, 4, 6, 0), 2);
    expect_miss("R5", mkva(1, 4, 6, 8), 2);

    // R8 back-to-back hits
    @(negedge clk);
    req_valid = 1'b1; req_addr = mkva(0, 5, 17, 12'h010);
    @(negedge clk);
    check("R8", "first valid", 32'(resp_valid), 32'd1);
    check("R8", "first paddr", resp_paddr, exp_pa(mkva(0, 5, 17, 12'h010)));
    req_addr = mkva(1, 5, 17, 12'h020);
    @(negedge clk);
    req_valid = 1'b0;
    check("R8", "second valid", 32'(resp_valid), 32'd1);
    check("R8", "second paddr", resp_paddr, exp_pa(mkva(1, 5, 17, 12'h020)));

    // R7 flush empties buffer
    flush();
    expect_miss("R7", mkva(0, 5, 17, 12'h123), 2);

    // R6 round robin: after flush fill 32 slots, 33rd evicts slot 0
    flush();
    for (int i = 0; i < 33; i++) expect_miss("R6", mkva(0, 1, 7*i, 0), 2);
    expect_hit("R6", mkva(0, 1, 7*1, 4));
    expect_miss("R6", mkva(0, 1, 0, 4), 2);
    expect_hit("R6", mkva(0, 1, 7*2, 4));
    expect_miss("R6", mkva(0, 1, 7*1, 4), 2);

    // random mix over a small pool, value checks only
    void'($urandom(32'd1234));
    for (int i = 0; i < 8; i++)
      pool[i] = {$urandom_range(1,0) == 1, 9'($urandom_range(511,0)), 10'($urandom_range(1023,0)), 12'h0};
    for (int i = 0; i < 200; i++) begin
      int cyc, rd; logic f; logic [31:0] pa, va;
      va = pool[$urandom_range(7,0)] | 32'($urandom_range(4095,0));
      if ($urandom_range(40,0) == 0) flush();
      xlate(va, cyc, f, pa, rd);
      check("R3", "rand fault", 32'(f), 32'(exp_fault(va)));
      check("R1", "rand paddr", pa, exp_pa(va));
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule